// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block carries 32-bit message words from one processor to another. It has two register-bus slave ports on one clock. The sender port writes words into a small first-in first-out queue. The receiver port reads them back out in the order they were written. A system that talks both ways uses two instances, one for each direction.

Both ports see the same status word. It shows whether the queue is empty and whether it holds data, so each side can poll before it acts. A sticky flag records any word that was lost because the queue was full. An interrupt enable bit gates an interrupt line that stays high while the queue holds data.

Reads are registered. Read data appears on the port in the cycle after the read strobe. It is zero in every cycle without a read.

Top module: `msg_mailbox`

## Requirements
- R1: A sender write at byte offset 0x0 appends its 32-bit word to the queue. A receiver read at offset 0x0 removes the oldest word and returns it on the receiver read data in the next cycle. Words leave in the order they were written.
- R2: Status (byte offset 0x8, readable from either port) bit 1 is 1 exactly when the queue holds one or more words.
- R3: Status bit 0 is 1 exactly when the queue holds no words.
- R4: The queue holds DEPTH words (default 4). A sender data write while the queue is full is dropped and leaves the stored words unchanged. Fullness is judged before any read in the same cycle.
- R5: A dropped write sets sticky status bit 2. A write of 1 to bit 2 at offset 0x8 from either port clears it. A write of 0 to bit 2 leaves it alone. A drop in the same cycle as a clear leaves the bit set.
- R6: A receiver read at offset 0x0 while the queue is empty returns zero and leaves the queue unchanged.
- R7: Status bit 3 is an interrupt enable, loaded from write-data bit 3 by a status write from either port. If both ports write status in the same cycle, the receiver's value is loaded. The irq output is 1 exactly when the enable is set and the queue holds data.
- R8: Reads at any offset other than 0x0 and 0x8 return zero. Writes there have no effect. A sender read at 0x0 returns zero and removes nothing. A receiver write at 0x0 stores nothing.
- R9: After reset the queue is empty, bits 2 and 3 are clear, irq is 0, both read data ports are zero, and status reads 0x1.
- R10: A sender data write and a receiver data read in the same cycle, with the queue neither full nor empty, both take effect. The word count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_addr | input | ADDR_W | Sender byte offset |
| snd_wr | input | 1 | Sender write strobe |
| snd_rd | input | 1 | Sender read strobe |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data, valid the cycle after the strobe |
| rcv_addr | input | ADDR_W | Receiver byte offset |
| rcv_wr | input | 1 | Receiver write strobe |
| rcv_rd | input | 1 | Receiver read strobe |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt: enable set and data waiting |

## Verification
The hardest cases need both ports active in the same clock cycle. These are a push and a pop together, on a half-full queue and on a full one, and a dropped push in the same cycle as a receiver write that clears the overflow flag. The bench reaches them with a task that drives both ports on one falling edge. The bench first fills the queue to the level each case needs. It then sweeps the fill level from zero to past full, and sweeps every undefined offset on both ports. All expected values come from a queue model kept in the bench.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W   = 32;
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 8;
  localparam int ST_EMPTY = 0;
  localparam int ST_AVAIL = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_IE    = 3;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         dropped
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CMAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX);
  a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wp)));
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && $stable(rp)));
  a_r10_push_pop: assert property (@(posedge clk) disable iff (rst)
    (!full && !empty && push && pop) |=> $stable(count));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic drop,
  input  logic clr_s,
  input  logic clr_r,
  input  logic ie_we_s,
  input  logic ie_s,
  input  logic ie_we_r,
  input  logic ie_r,
  output logic ovf,
  output logic ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      ie  <= 1'b0;
    end else begin
      if (drop)                ovf <= 1'b1;
      else if (clr_s || clr_r) ovf <= 1'b0;
      if (ie_we_r)      ie <= ie_r;
      else if (ie_we_s) ie <= ie_s;
    end
  end

  a_r5_ovf_set: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
  a_r5_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_s && !clr_r) |=> ovf);
  a_r7_ie_hold: assert property (@(posedge clk) disable iff (rst)
    (!ie_we_s && !ie_we_r) |=> $stable(ie));
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic              snd_wr,
  input  logic              snd_rd,
  input  logic [31:0]       snd_wdata,
  output logic [31:0]       snd_rdata,
  input  logic [ADDR_W-1:0] rcv_addr,
  input  logic              rcv_wr,
  input  logic              rcv_rd,
  input  logic [31:0]       rcv_wdata,
  output logic [31:0]       rcv_rdata,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [WORD_W-1:0] head;
  logic [CW-1:0]     count;
  logic              full, empty, dropped, ovf, ie;
  logic              push, pop;
  logic [31:0]       stat;
  logic              unused_bits;

  assign push = snd_wr && (snd_addr == A_DATA);
  assign pop  = rcv_rd && (rcv_addr == A_DATA);
  assign unused_bits = ^{rcv_wdata[31:4], rcv_wdata[1:0], snd_wdata[1:0], full};

  mbox_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wdata(snd_wdata),
    .head(head), .count(count), .full(full), .empty(empty), .dropped(dropped)
  );

  mbox_ctrl u_ctrl (
    .clk(clk), .rst(rst), .drop(dropped),
    .clr_s(snd_wr && (snd_addr == A_STAT) && snd_wdata[ST_OVF]),
    .clr_r(rcv_wr && (rcv_addr == A_STAT) && rcv_wdata[ST_OVF]),
    .ie_we_s(snd_wr && (snd_addr == A_STAT)), .ie_s(snd_wdata[ST_IE]),
    .ie_we_r(rcv_wr && (rcv_addr == A_STAT)), .ie_r(rcv_wdata[ST_IE]),
    .ovf(ovf), .ie(ie)
  );

  always_comb begin
    stat           = '0;
    stat[ST_EMPTY] = empty;
    stat[ST_AVAIL] = !empty;
    stat[ST_OVF]   = ovf;
    stat[ST_IE]    = ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snd_rdata <= '0;
      rcv_rdata <= '0;
    end else begin
      snd_rdata <= (snd_rd && snd_addr == A_STAT) ? stat : '0;
      if (rcv_rd && rcv_addr == A_STAT)    rcv_rdata <= stat;
      else if (pop && !empty)              rcv_rdata <= head;
      else                                 rcv_rdata <= '0;
    end
  end

  assign irq = ie && (count != '0);

  a_r8_snd_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(snd_rd) |-> (snd_rdata == '0));
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (rcv_rdata == '0));
  a_r1_no_pop_no_data: assert property (@(posedge clk) disable iff (rst)
    !$past(rcv_rd) |-> (rcv_rdata == '0));
endmodule

// File: tb/msg_mailbox_tb.sv
module msg_mailbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 0, rst = 1;
  logic [3:0] snd_addr = 0, rcv_addr = 0;
  logic snd_wr = 0, snd_rd = 0, rcv_wr = 0, rcv_rd = 0;
  logic [31:0] snd_wdata = 0, rcv_wdata = 0, snd_rdata, rcv_rdata;
  logic irq;

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  bit m_ov = 0, m_ie = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_mailbox #(.DEPTH(DEPTH), .ADDR_W(4)) u_dut (
    .clk(clk), .rst(rst),
    .snd_addr(snd_addr), .snd_wr(snd_wr), .snd_rd(snd_rd), .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_addr(rcv_addr), .rcv_wr(rcv_wr), .rcv_rd(rcv_rd), .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    return {28'd0, m_ie, m_ov, q.size() != 0, q.size() == 0};
  endfunction

  task automatic wr(input bit rcv, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    if (rcv) begin rcv_addr = a; rcv_wdata = d; rcv_wr = 1; end
    else begin snd_addr = a; snd_wdata = d; snd_wr = 1; end
    @(negedge clk);
    snd_wr = 0; rcv_wr = 0;
  endtask

  task automatic rd(input bit rcv, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    if (rcv) begin rcv_addr = a; rcv_rd = 1; end
    else begin snd_addr = a; snd_rd = 1; end
    @(negedge clk);
    d = rcv ? rcv_rdata : snd_rdata;
    snd_rd = 0; rcv_rd = 0;
  endtask

  task automatic push(input logic [31:0] d);
    wr(0, 4'h0, d);
    if (q.size() < DEPTH) q.push_back(d); else m_ov = 1;
  endtask

  task automatic pop_chk(input string req);
    logic [31:0] d, e;
    e = (q.size() != 0) ? q.pop_front() : 32'd0;
    rd(1, 4'h0, d);
    chk(req, d, e);
  endtask

  task automatic stat_chk(input string req);
    logic [31:0] d;
    rd(0, 4'h8, d); chk({req, " snd status"}, d, exp_stat());
    rd(1, 4'h8, d); chk({req, " rcv status"}, d, exp_stat());
  endtask

  // both ports in one cycle: sender data push + receiver action
  task automatic dual(input logic [31:0] d, input bit rcv_is_pop, input logic [31:0] rw,
                      output logic [31:0] rdv);
    bit was_full;
    @(negedge clk);
    was_full = (q.size() == DEPTH);
    snd_addr = 0; snd_wdata = d; snd_wr = 1;
    if (rcv_is_pop) begin rcv_addr = 0; rcv_rd = 1; end
    else begin rcv_addr = 4'h8; rcv_wdata = rw; rcv_wr = 1; end
    @(negedge clk);
    rdv = rcv_rdata;
    snd_wr = 0; rcv_wr = 0; rcv_rd = 0;
    if (rcv_is_pop) begin
      if (was_full) m_ov = 1;
      else q.push_back(d);
      void'(q.pop_front());
    end else begin
      m_ie = rw[3];
      if (was_full) m_ov = 1;
      else begin q.push_back(d); if (rw[2]) m_ov = 0; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    chk("R9 irq", {31'd0, irq}, 0);
    chk("R9 snd_rdata", snd_rdata, 0);
    chk("R9 rcv_rdata", rcv_rdata, 0);
    rd(0, 4'h8, d); chk("R9 status", d, 32'h1);

    // R1 R2 R3 R4 R5 fill sweep past full, then drain
    for (int n = 1; n <= DEPTH + 2; n++) begin
      push(32'hA5000000 + n * 32'h01010101);
      stat_chk("R2 R3 R4 fill");
    end
    for (int n = 0; n <= DEPTH; n++) begin
      pop_chk("R1 R4 order");
      stat_chk("R3 drain");
    end
    pop_chk("R6 empty read zero");
    stat_chk("R6 empty unchanged");

    // R5 write 0 keeps, write 1 clears (from receiver)
    wr(0, 4'h8, 32'h0); stat_chk("R5 write0 keeps");
    wr(1, 4'h8, 32'h4); m_ov = 0; stat_chk("R5 rcv clear");
    // R5 clear from sender
    for (int n = 0; n <= DEPTH; n++) push(32'h11 + n);
    wr(0, 4'h8, 32'h4); m_ov = 0; stat_chk("R5 snd clear");
    while (q.size() != 0) pop_chk("R1 drain");

    // R7 interrupt
    wr(0, 4'h8, 32'h8); m_ie = 1;
    chk("R7 irq empty", {31'd0, irq}, 0);
    push(32'hDEADBEEF);
    chk("R7 irq data", {31'd0, irq}, 1);
    stat_chk("R7 ie readback");
    pop_chk("R1 single");
    chk("R7 irq drained", {31'd0, irq}, 0);
    push(32'h12345678);
    wr(1, 4'h8, 32'h0); m_ie = 0;
    chk("R7 irq disabled", {31'd0, irq}, 0);

    // R8 undefined offsets, both ports, with one word queued
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 8) continue;
      wr(0, a[3:0], 32'hFFFFFFFF);
      wr(1, a[3:0], 32'hFFFFFFFF);
      rd(0, a[3:0], d); chk("R8 snd undef read", d, 0);
      rd(1, a[3:0], d); chk("R8 rcv undef read", d, 0);
    end
    stat_chk("R8 undef writes ignored");
    rd(0, 4'h0, d); chk("R8 snd data read", d, 0);
    wr(1, 4'h0, 32'hCAFEF00D);
    stat_chk("R8 no pop no push");
    pop_chk("R8 word intact");
    stat_chk("R8 empty after");

    // R10 simultaneous push/pop, mid-level
    push(32'h100); push(32'h200);
    e = q[0];
    dual(32'h300, 1, 0, d); chk("R10 pop data", d, e);
    stat_chk("R10 count");
    while (q.size() != 0) pop_chk("R10 order");

    // R4 push while full with same-cycle pop: push dropped
    for (int n = 0; n < DEPTH; n++) push(32'h40 + n);
    e = q[0];
    dual(32'h999, 1, 0, d); chk("R4 full pop data", d, e);
    stat_chk("R4 full push dropped");
    while (q.size() != 0) pop_chk("R4 order");
    wr(1, 4'h8, 32'h4); m_ov = 0;

    // R5 set wins over clear; R7 receiver ie on same cycle
    for (int n = 0; n < DEPTH; n++) push(32'h70 + n);
    dual(32'h777, 0, 32'hC, d);
    stat_chk("R5 set wins R7 rcv ie");
    chk("R7 irq set", {31'd0, irq}, 1);
    // R7 both ports write status same cycle: receiver wins
    @(negedge clk);
    snd_addr = 4'h8; snd_wdata = 32'h8; snd_wr = 1;
    rcv_addr = 4'h8; rcv_wdata = 32'h0; rcv_wr = 1;
    @(negedge clk);
    snd_wr = 0; rcv_wr = 0; m_ie = 0;
    stat_chk("R7 rcv priority");
    while (q.size() != 0) pop_chk("R1 final drain");
    stat_chk("R3 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule